// File: doc/BRIEF.md
# Block Cipher Chaining Sequencer

This block runs a counted series of 128-bit data blocks through a separate block-cipher core and applies a chaining mode around that core. A single packed control word is presented with a start pulse. It picks the mode (electronic codebook, cipher block chaining, cipher feedback, output feedback or counter), the direction, and the round-count and key-size values that are handed to the core unchanged. The sequencer keeps the chaining or counter value and the number of blocks still to go. It takes plaintext or ciphertext on a valid/ready input stream and returns results on a valid/ready output stream. The core itself, its key schedule and any memory fetch are outside this block.

Blocks are handled one at a time: accept an input block, send one request to the core, wait for the response, then emit one result. A run can be paused at a block boundary. The sequencer then goes idle with its chaining value and remaining count intact, and a resume pulse continues exactly where it stopped. A control word that breaks the encoding rules raises an error flag, and nothing is processed.

Top module: `blk_chain_seq`

## Requirements
- R1: Control word layout (20 bits):
  - bits 3:0 hold the round count.
  - bits 8:4 hold a one-hot mode field: bit 4 ECB, bit 5 CBC, bit 6 CFB, bit 7 OFB, bit 8 CTR.
  - bit 9 is 1 for decrypt.
  - bits 11:10 hold the key size: 00 for 128, 01 for 192, 10 for 256, with 11 reserved.
  - bits 19:12 are reserved and must be zero.
  A start with a mode field that does not have exactly one bit set, with key size 11, or with any reserved bit set raises `cfg_err` in the next cycle. The sequencer then stays idle: `busy` stays low, `in_ready` stays low and `done` does not pulse.
- R2: A start with a legal word clears `cfg_err` and loads the IV and the block count; `blocks_left` shows the count and `busy` is high in the next cycle. A legal start with a count of zero processes nothing and pulses `done` in the next cycle.
- R3: ECB: the result is the core output for the input block, with the core run in decrypt direction when bit 9 is 1.
- R4: CBC: when encrypting, the core input is the input block XOR the chaining value, and the result becomes the new chaining value. When decrypting, the result is the core's decrypt output XOR the chaining value, and the input block becomes the new chaining value.
- R5: CFB: the core encrypts the chaining value and the result is the input XOR that core output. The new chaining value is the ciphertext: the result when encrypting, the input block when decrypting.
- R6: OFB: the core encrypts the chaining value, the result is the input XOR the core output, and the core output becomes the new chaining value, in both directions.
- R7: CTR: the core encrypts the counter, the result is the input XOR the core output, and the counter then increases by one modulo 2^128 (all ones wraps to zero).
- R8: Each core request carries the round count and key size from the control word. `core_req_decrypt` is high only for ECB or CBC with bit 9 set.
- R9: `blocks_left` drops by one per block when the core responds. `done` pulses in the cycle after the output handshake of the last block, with `busy` low.
- R10: When `pause` is high while the sequencer waits for input, it goes idle at that block boundary and accepts no input. The chaining value and `blocks_left` are kept, and a `resume` pulse continues the run with results identical to an uninterrupted run.
- R11: While `core_req_valid` is high without `core_req_ready`, the request data stays stable. While `out_valid` is high without `out_ready`, `out_data` stays stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a run with `ctrl_word`, `iv`, `blk_count` (taken while idle) |
| ctrl_word | input | 20 | Packed mode/direction/rounds/key-size word |
| iv | input | 128 | Initial chaining value or counter |
| blk_count | input | CNT_W | Number of 128-bit blocks in the run |
| pause | input | 1 | Stop at the next block boundary |
| resume | input | 1 | Continue a paused run |
| in_valid | input | 1 | Input block valid |
| in_ready | output | 1 | Sequencer accepts an input block |
| in_data | input | 128 | Input block |
| out_valid | output | 1 | Result block valid |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | 128 | Result block |
| core_req_valid | output | 1 | Request to the cipher core |
| core_req_ready | input | 1 | Core accepts the request |
| core_req_data | output | 128 | Block sent to the core |
| core_req_decrypt | output | 1 | Core direction, 1 = decrypt |
| core_req_rounds | output | 4 | Round count for the core |
| core_req_keysize | output | 2 | Key size code for the core |
| core_rsp_valid | input | 1 | Core result valid (single-cycle pulse) |
| core_rsp_data | input | 128 | Core result |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle pulse at the end of a run |
| cfg_err | output | 1 | Last start carried an illegal control word |
| blocks_left | output | CNT_W | Blocks still to be processed |

## Verification
The hardest situation to reach from the ports is a run paused mid-sequence and resumed. The internal chaining value can only be seen through the results of the blocks after resume. The bench pauses a four-block CBC encryption after two blocks and waits while the sequencer sits idle. It then resumes and compares the last two results against the model's continued chain, which catches any lost or reloaded chaining state. The counter wrap from all ones to zero is reached directly by starting a CTR run with an all-ones IV. The encoding sweep walks all 32 mode-field values as well as every reserved bit and the reserved key size.

// File: rtl/blk_chain_pkg.sv
package blk_chain_pkg;

    localparam int BLK_W       = 128;
    localparam int MODE_N      = 5;
    localparam int RND_W       = 4;
    localparam int KS_W        = 2;
    localparam int CW_W        = 20;
    localparam int CW_RND_LSB  = 0;
    localparam int CW_MODE_LSB = CW_RND_LSB + RND_W;
    localparam int CW_DEC_BIT  = CW_MODE_LSB + MODE_N;
    localparam int CW_KS_LSB   = CW_DEC_BIT + 1;
    localparam int CW_RSV_LSB  = CW_KS_LSB + KS_W;

    localparam int M_ECB = 0;
    localparam int M_CBC = 1;
    localparam int M_CFB = 2;
    localparam int M_OFB = 3;
    localparam int M_CTR = 4;

    localparam logic [KS_W-1:0] KS_RESERVED = 2'b11;

    typedef struct packed {
        logic [MODE_N-1:0] mode_oh;
        logic              decrypt;
        logic [KS_W-1:0]   key_size;
        logic [RND_W-1:0]  rounds;
    } cfg_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_TAKE,
        ST_SEND,
        ST_WAIT,
        ST_EMIT
    } seq_state_e;

    function automatic logic exactly_one(input logic [MODE_N-1:0] v);
        int n;
        n = 0;
        for (int i = 0; i < MODE_N; i++) begin
            n = n + int'(v[i]);
        end
        return n == 1;
    endfunction

    // Block handed to the core for mode m
    function automatic logic [BLK_W-1:0] step_core_in(
        input int m, input logic dec,
        input logic [BLK_W-1:0] chain, input logic [BLK_W-1:0] din);
        case (m)
            M_ECB:   return din;
            M_CBC:   return dec ? din : (din ^ chain);
            default: return chain;
        endcase
    endfunction

    // Result block for mode m
    function automatic logic [BLK_W-1:0] step_result(
        input int m, input logic dec, input logic [BLK_W-1:0] chain,
        input logic [BLK_W-1:0] din, input logic [BLK_W-1:0] core);
        case (m)
            M_ECB:   return core;
            M_CBC:   return dec ? (core ^ chain) : core;
            default: return din ^ core;
        endcase
    endfunction

    // Chaining value after the block for mode m
    function automatic logic [BLK_W-1:0] step_chain(
        input int m, input logic dec, input logic [BLK_W-1:0] chain,
        input logic [BLK_W-1:0] din, input logic [BLK_W-1:0] core);
        case (m)
            M_ECB:   return chain;
            M_CBC:   return dec ? din : core;
            M_CFB:   return dec ? din : (din ^ core);
            M_OFB:   return core;
            default: return chain + {{(BLK_W-1){1'b0}}, 1'b1};
        endcase
    endfunction

endpackage

// File: rtl/cw_check.sv
module cw_check
    import blk_chain_pkg::*;
(
    input  logic [CW_W-1:0] cw,
    output cfg_t            cfg,
    output logic            legal
);
    logic [MODE_N-1:0] mode_f;
    logic [KS_W-1:0]   ks_f;
    logic              mode_ok;
    logic              ks_ok;
    logic              rsv_ok;

    assign mode_f  = cw[CW_MODE_LSB +: MODE_N];
    assign ks_f    = cw[CW_KS_LSB +: KS_W];
    assign mode_ok = exactly_one(mode_f);
    assign ks_ok   = (ks_f != KS_RESERVED);
    assign rsv_ok  = ~|cw[CW_W-1:CW_RSV_LSB];
    assign legal   = mode_ok && ks_ok && rsv_ok;

    always_comb begin
        cfg.mode_oh  = mode_f;
        cfg.decrypt  = cw[CW_DEC_BIT];
        cfg.key_size = ks_f;
        cfg.rounds   = cw[CW_RND_LSB +: RND_W];
    end

endmodule

// File: rtl/chain_step.sv
module chain_step
    import blk_chain_pkg::*;
(
    input  logic [MODE_N-1:0] mode_oh,
    input  logic              decrypt,
    input  logic [BLK_W-1:0]  chain,
    input  logic [BLK_W-1:0]  din,
    input  logic [BLK_W-1:0]  core_out,
    output logic [BLK_W-1:0]  core_in,
    output logic              core_dec,
    output logic [BLK_W-1:0]  result,
    output logic [BLK_W-1:0]  chain_next
);
    logic [BLK_W-1:0] c_in  [MODE_N];
    logic [BLK_W-1:0] c_res [MODE_N];
    logic [BLK_W-1:0] c_nxt [MODE_N];

    for (genvar i = 0; i < MODE_N; i++) begin : g_mode
        assign c_in[i]  = step_core_in(i, decrypt, chain, din) & {BLK_W{mode_oh[i]}};
        assign c_res[i] = step_result(i, decrypt, chain, din, core_out) & {BLK_W{mode_oh[i]}};
        assign c_nxt[i] = step_chain(i, decrypt, chain, din, core_out) & {BLK_W{mode_oh[i]}};
    end

    always_comb begin
        core_in    = '0;
        result     = '0;
        chain_next = '0;
        for (int i = 0; i < MODE_N; i++) begin
            core_in    = core_in | c_in[i];
            result     = result | c_res[i];
            chain_next = chain_next | c_nxt[i];
        end
    end

    // Feedback modes always run the core forward
    assign core_dec = decrypt & (mode_oh[M_ECB] | mode_oh[M_CBC]);

endmodule

// File: rtl/blk_chain_seq.sv
module blk_chain_seq
    import blk_chain_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [CW_W-1:0]  ctrl_word,
    input  logic [BLK_W-1:0] iv,
    input  logic [CNT_W-1:0] blk_count,
    input  logic             pause,
    input  logic             resume,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [BLK_W-1:0] in_data,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [BLK_W-1:0] out_data,
    output logic             core_req_valid,
    input  logic             core_req_ready,
    output logic [BLK_W-1:0] core_req_data,
    output logic             core_req_decrypt,
    output logic [RND_W-1:0] core_req_rounds,
    output logic [KS_W-1:0]  core_req_keysize,
    input  logic             core_rsp_valid,
    input  logic [BLK_W-1:0] core_rsp_data,
    output logic             busy,
    output logic             done,
    output logic             cfg_err,
    output logic [CNT_W-1:0] blocks_left
);
    localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    seq_state_e       state_q;
    cfg_t             cfg_q;
    cfg_t             cw_cfg;
    logic             cw_legal;
    logic [BLK_W-1:0] chain_q;
    logic [BLK_W-1:0] din_q;
    logic [BLK_W-1:0] dout_q;
    logic [CNT_W-1:0] cnt_q;
    logic             err_q;
    logic             done_q;
    logic             susp_q;
    logic [BLK_W-1:0] st_core_in;
    logic [BLK_W-1:0] st_result;
    logic [BLK_W-1:0] st_chain;
    logic             st_core_dec;

    cw_check u_cw (
        .cw    (ctrl_word),
        .cfg   (cw_cfg),
        .legal (cw_legal)
    );

    chain_step u_step (
        .mode_oh    (cfg_q.mode_oh),
        .decrypt    (cfg_q.decrypt),
        .chain      (chain_q),
        .din        (din_q),
        .core_out   (core_rsp_data),
        .core_in    (st_core_in),
        .core_dec   (st_core_dec),
        .result     (st_result),
        .chain_next (st_chain)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cfg_q   <= '0;
            chain_q <= '0;
            din_q   <= '0;
            dout_q  <= '0;
            cnt_q   <= '0;
            err_q   <= 1'b0;
            done_q  <= 1'b0;
            susp_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        susp_q <= 1'b0;
                        if (!cw_legal) begin
                            err_q <= 1'b1;
                        end else begin
                            err_q   <= 1'b0;
                            cfg_q   <= cw_cfg;
                            chain_q <= iv;
                            cnt_q   <= blk_count;
                            if (blk_count == '0) begin
                                done_q <= 1'b1;
                            end else begin
                                state_q <= ST_TAKE;
                            end
                        end
                    end else if (resume && susp_q) begin
                        susp_q  <= 1'b0;
                        state_q <= ST_TAKE;
                    end
                end
                ST_TAKE: begin
                    if (pause) begin
                        susp_q  <= 1'b1;
                        state_q <= ST_IDLE;
                    end else if (in_valid) begin
                        din_q   <= in_data;
                        state_q <= ST_SEND;
                    end
                end
                ST_SEND: begin
                    if (core_req_ready) begin
                        state_q <= ST_WAIT;
                    end
                end
                ST_WAIT: begin
                    if (core_rsp_valid) begin
                        dout_q  <= st_result;
                        chain_q <= st_chain;
                        cnt_q   <= cnt_q - CNT_ONE;
                        state_q <= ST_EMIT;
                    end
                end
                ST_EMIT: begin
                    if (out_ready) begin
                        if (cnt_q == '0) begin
                            done_q  <= 1'b1;
                            state_q <= ST_IDLE;
                        end else begin
                            state_q <= ST_TAKE;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign busy             = (state_q != ST_IDLE);
    assign in_ready         = (state_q == ST_TAKE) && !pause;
    assign out_valid        = (state_q == ST_EMIT);
    assign out_data         = dout_q;
    assign core_req_valid   = (state_q == ST_SEND);
    assign core_req_data    = st_core_in;
    assign core_req_decrypt = st_core_dec;
    assign core_req_rounds  = cfg_q.rounds;
    assign core_req_keysize = cfg_q.key_size;
    assign done             = done_q;
    assign cfg_err          = err_q;
    assign blocks_left      = cnt_q;

    AST_ERR_KEEPS_IDLE: assert property (@(posedge clk) disable iff (rst)
        cfg_err |-> !busy); // R1
    AST_BUSY_MODE_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        busy |-> ($countones(cfg_q.mode_oh) == 1)); // R1
    AST_CTR_STEP: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_WAIT && core_rsp_valid && cfg_q.mode_oh[M_CTR])
        |=> chain_q == $past(chain_q) + {{(BLK_W-1){1'b0}}, 1'b1}); // R7
    AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_WAIT && core_rsp_valid) |=> blocks_left == $past(blocks_left) - CNT_ONE); // R9
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy); // R9
    AST_PAUSE_NO_TAKE: assert property (@(posedge clk) disable iff (rst)
        pause |-> !in_ready); // R10
    AST_REQ_STABLE: assert property (@(posedge clk) disable iff (rst)
        (core_req_valid && !core_req_ready) |=> core_req_valid && $stable(core_req_data)); // R11
    AST_OUT_STABLE: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> out_valid && $stable(out_data)); // R11

endmodule

// File: tb/blk_chain_seq_tb.sv
`timescale 1ns/1ps
module blk_chain_seq_tb_top;
    localparam int CNT_W = 16;
    localparam logic [127:0] KC = 128'h3c6e_f372_a54f_f53a_510e_527f_9b05_688c;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic [19:0]  ctrl_word = '0;
    logic [127:0] iv = '0;
    logic [CNT_W-1:0] blk_count = '0;
    logic         pause = 1'b0;
    logic         resume = 1'b0;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic [127:0] in_data = '0;
    logic         out_valid;
    logic         out_ready = 1'b0;
    logic [127:0] out_data;
    logic         core_req_valid;
    logic         core_req_ready;
    logic [127:0] core_req_data;
    logic         core_req_decrypt;
    logic [3:0]   core_req_rounds;
    logic [1:0]   core_req_keysize;
    logic         core_rsp_valid;
    logic [127:0] core_rsp_data;
    logic         busy, done, cfg_err;
    logic [CNT_W-1:0] blocks_left;

    int n_chk = 0;
    int n_fail = 0;
    logic [3:0] exp_rnd = '0;
    logic [1:0] exp_ks = '0;
    logic       exp_cdec = 1'b0;

    always #2.5 clk = ~clk;

    blk_chain_seq #(.CNT_W(CNT_W)) dut_i (
        .clk(clk), .rst(rst), .start(start), .ctrl_word(ctrl_word), .iv(iv),
        .blk_count(blk_count), .pause(pause), .resume(resume),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .core_req_valid(core_req_valid), .core_req_ready(core_req_ready),
        .core_req_data(core_req_data), .core_req_decrypt(core_req_decrypt),
        .core_req_rounds(core_req_rounds), .core_req_keysize(core_req_keysize),
        .core_rsp_valid(core_rsp_valid), .core_rsp_data(core_rsp_data),
        .busy(busy), .done(done), .cfg_err(cfg_err), .blocks_left(blocks_left)
    );

    function automatic logic [127:0] menc(input logic [127:0] x);
        return {x[114:0], x[127:115]} ^ KC;
    endfunction
    function automatic logic [127:0] mdec(input logic [127:0] y);
        logic [127:0] z;
        z = y ^ KC;
        return {z[12:0], z[127:13]};
    endfunction

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Cipher core model with variable ready and latency
    logic [7:0]   lfsr;
    logic         pend;
    logic [1:0]   lat;
    logic [127:0] pend_d;
    always @(posedge clk) begin
        core_rsp_valid <= 1'b0;
        if (rst) begin
            lfsr <= 8'h5b; pend <= 1'b0; lat <= '0;
            core_req_ready <= 1'b0; core_rsp_data <= '0; pend_d <= '0;
        end else begin
            lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            if (!pend) begin
                core_req_ready <= lfsr[0];
                if (core_req_valid && core_req_ready) begin
                    chk("R8 rounds/keysize/dir", {core_req_rounds, core_req_keysize, core_req_decrypt},
                        {exp_rnd, exp_ks, exp_cdec});
                    pend <= 1'b1;
                    lat <= lfsr[2:1];
                    core_req_ready <= 1'b0;
                    pend_d <= core_req_decrypt ? mdec(core_req_data) : menc(core_req_data);
                end
            end else if (lat == 2'd0) begin
                core_rsp_valid <= 1'b1;
                core_rsp_data <= pend_d;
                pend <= 1'b0;
            end else begin
                lat <= lat - 2'd1;
            end
        end
    end

    function automatic logic [19:0] mkcw(input logic [3:0] rnd, input logic [4:0] m,
                                         input logic dec, input logic [1:0] ks, input logic [7:0] rsv);
        return {rsv, ks, dec, m, rnd};
    endfunction

    task automatic ref_step(input int m, input logic dec, input logic [127:0] d,
                            inout logic [127:0] ch, output logic [127:0] q);
        case (m)
            0: q = dec ? mdec(d) : menc(d);
            1: if (dec) begin q = mdec(d) ^ ch; ch = d; end
               else begin q = menc(d ^ ch); ch = q; end
            2: begin q = d ^ menc(ch); ch = dec ? d : q; end
            3: begin ch = menc(ch); q = d ^ ch; end
            default: begin q = d ^ menc(ch); ch = ch + 128'd1; end
        endcase
    endtask

    task automatic start_run(input logic [19:0] cw, input logic [127:0] ivv, input logic [CNT_W-1:0] n);
        ctrl_word = cw; iv = ivv; blk_count = n; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic do_block(input logic [127:0] d, output logic [127:0] q);
        logic [127:0] held;
        in_data = d; in_valid = 1'b1;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        while (!out_valid) @(negedge clk);
        held = out_data;
        @(negedge clk);
        chk("R11 out held", {out_valid, out_data}, {1'b1, held});
        out_ready = 1'b1;
        q = out_data;
        @(negedge clk);
        out_ready = 1'b0;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        string mreq [5];
        logic [127:0] ch, q, e, d;
        mreq[0] = "R3"; mreq[1] = "R4"; mreq[2] = "R5"; mreq[3] = "R6"; mreq[4] = "R7";

        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R2 reset state", {busy, done, cfg_err, out_valid, core_req_valid, in_ready}, '0);

        // R1: sweep the whole mode field, then key size and reserved bits
        for (int mv = 0; mv < 32; mv++) begin
            logic lg;
            lg = ($countones(mv[4:0]) == 1);
            start_run(mkcw(4'd3, mv[4:0], 1'b0, 2'b00, 8'h00), '0, '0);
            chk("R1 mode field legality", {cfg_err, done, busy, in_ready}, {!lg, lg, 1'b0, 1'b0});
        end
        start_run(mkcw(4'd3, 5'b00001, 1'b0, 2'b11, 8'h00), '0, 16'd2);
        chk("R1 reserved key size", {cfg_err, busy, in_ready, done}, 4'b1000);
        for (int b = 0; b < 8; b++) begin
            start_run(mkcw(4'd3, 5'b00010, 1'b0, 2'b01, 8'(1 << b)), '0, 16'd2);
            chk("R1 reserved bit", {cfg_err, busy, in_ready, done}, 4'b1000);
        end
        @(negedge clk);
        chk("R1 stays idle", {cfg_err, busy, in_ready}, 3'b100);

        // Every mode in both directions
        for (int m = 0; m < 5; m++) begin
            for (int dr = 0; dr < 2; dr++) begin
                exp_rnd = 4'(m * 2 + dr + 1);
                exp_ks = 2'(m % 3);
                exp_cdec = dr[0] && (m < 2);
                ch = 128'h0f1e_2d3c_4b5a_6978_8796_a5b4_c3d2_e1f0 ^ 128'(m * 77 + dr);
                start_run(mkcw(exp_rnd, 5'(1 << m), dr[0], exp_ks, 8'h00), ch, 16'd3);
                chk("R2 loaded", {cfg_err, busy, 16'(blocks_left)}, {1'b0, 1'b1, 16'd3});
                for (int b = 0; b < 3; b++) begin
                    d = {32'(m), 32'(dr), 32'(b), 32'hc0de_0000 + 32'(b * 13)};
                    do_block(d, q);
                    ref_step(m, dr[0], d, ch, e);
                    chk(mreq[m], q, e);
                end
                chk("R9 done after last block", {done, busy, 16'(blocks_left)}, {1'b1, 1'b0, 16'd0});
                @(negedge clk);
                chk("R9 done is a pulse", {done}, 1'b0);
            end
        end

        // R7: counter wraps from all ones to zero
        exp_rnd = 4'd10; exp_ks = 2'b10; exp_cdec = 1'b0;
        start_run(mkcw(exp_rnd, 5'b10000, 1'b0, exp_ks, 8'h00), {128{1'b1}}, 16'd2);
        d = 128'h1111_2222_3333_4444_5555_6666_7777_8888;
        do_block(d, q);
        chk("R7 counter all ones", q, d ^ menc({128{1'b1}}));
        do_block(d, q);
        chk("R7 counter wrapped to zero", q, d ^ menc('0));

        // R10: pause after two of four CBC blocks, then resume
        exp_rnd = 4'd14; exp_ks = 2'b10; exp_cdec = 1'b0;
        ch = 128'hfeed_face_cafe_beef_0123_4567_89ab_cdef;
        start_run(mkcw(exp_rnd, 5'b00010, 1'b0, exp_ks, 8'h00), ch, 16'd4);
        for (int b = 0; b < 2; b++) begin
            d = 128'(b + 1) * 128'h0101_0101;
            do_block(d, q);
            ref_step(1, 1'b0, d, ch, e);
            chk("R4 before pause", q, e);
        end
        pause = 1'b1;
        @(negedge clk);
        pause = 1'b0;
        chk("R10 paused", {busy, in_ready, 16'(blocks_left)}, {1'b0, 1'b0, 16'd2});
        in_valid = 1'b1; in_data = 128'hdead;
        repeat (3) @(negedge clk);
        chk("R10 no input taken while paused", {busy, in_ready, out_valid, 16'(blocks_left)},
            {1'b0, 1'b0, 1'b0, 16'd2});
        in_valid = 1'b0;
        resume = 1'b1;
        @(negedge clk);
        resume = 1'b0;
        chk("R10 resumed", {busy}, 1'b1);
        for (int b = 2; b < 4; b++) begin
            d = 128'(b + 1) * 128'h0101_0101;
            do_block(d, q);
            ref_step(1, 1'b0, d, ch, e);
            chk("R10 continued chain", q, e);
        end
        chk("R9 done after resumed run", {done, busy}, 2'b10);

        // R2: legal start with zero blocks
        start_run(mkcw(4'd1, 5'b00100, 1'b1, 2'b00, 8'h00), '0, '0);
        chk("R2 zero count", {done, busy, cfg_err, in_ready}, 4'b1000);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule